// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the control side of hazard handling for a scalar, in-order, five-stage pipeline (fetch, decode, execute, memory, writeback). It reads the register numbers, write enables, load flags and branch flags held in the inter-stage registers. From them it drives hold enables for the program counter and the fetch/decode register, a bubble request for the decode/execute register, a squash request for the fetch/decode register, and a two-bit operand source select for each ALU input.

Every instruction commits its register write in the fifth stage, and the register file is written early in a cycle and read late in it. Data hazards on ALU results are therefore removed by forwarding alone. A load whose result is needed by the very next instruction costs one stall cycle. A branch costs a fixed three-cycle fetch shadow and is not predicted.

The outputs are combinational in the current stage contents. The only state is the branch shadow counter.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While `rst` is high, `pc_hold`, `fd_hold`, `fd_flush` and `de_bubble` are 0 and both selects are 2'b00, whatever the inputs. Reset also clears any branch shadow that is in progress, so no flush follows the release of reset.
- R2: An operand select is 2'b10 (execute/memory result) when `mem_wen` is 1, `mem_rd` is nonzero and `mem_rd` equals that operand's source register. This holds even when the writeback register matches as well.
- R3: An operand select is 2'b01 (memory/writeback result) when the R2 condition fails and `wb_wen` is 1, `wb_rd` is nonzero and `wb_rd` equals that operand's source register.
- R4: Otherwise the select is 2'b00 (register file). In particular, a destination of register 0 or a low write enable never produces forwarding.
- R5: A load-use hazard exists when `ex_load` and `ex_wen` are 1, `ex_rd` is nonzero, and `ex_rd` equals `dec_rs1` or `dec_rs2`. During it, `pc_hold`, `fd_hold` and `de_bubble` are 1 and `fd_flush` is 0.
- R6: A matching producer in execute that is not a load, has its write enable low, or writes register 0 causes no stall. All four hazard outputs are then 0.
- R7: A branch in decode with no load-use hazard starts a shadow. `pc_hold` and `fd_flush` are 1 for exactly three consecutive cycles, beginning in that cycle, and `fd_hold` and `de_bubble` stay 0.
- R8: When a branch in decode meets a load-use hazard, the stall comes first. In that cycle `fd_flush` is 0, and the three-cycle shadow begins in the next cycle.
- R9: The two operand selects are computed independently from `ex_rs1` and `ex_rs2`.
- R10: During the second and third shadow cycles, `dec_branch` and any load-use match are ignored. The shadow is not extended and no bubble is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs1 | input | REG_AW | First source register of the instruction in decode |
| dec_rs2 | input | REG_AW | Second source register of the instruction in decode |
| dec_branch | input | 1 | Instruction in decode is a branch |
| ex_rs1 | input | REG_AW | First source register of the instruction in execute |
| ex_rs2 | input | REG_AW | Second source register of the instruction in execute |
| ex_rd | input | REG_AW | Destination of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_AW | Destination of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| wb_rd | input | REG_AW | Destination of the instruction in writeback |
| wb_wen | input | 1 | Instruction in writeback writes a register |
| pc_hold | output | 1 | Hold the program counter |
| fd_hold | output | 1 | Hold the fetch/decode register |
| fd_flush | output | 1 | Load a bubble into the fetch/decode register |
| de_bubble | output | 1 | Clear control bits entering decode/execute |
| fwd_a | output | 2 | Source select for the first ALU operand |
| fwd_b | output | 2 | Source select for the second ALU operand |

## Verification
The assertions check, on every cycle, the invariants that tie the outputs together. A bubble always comes with both holds and never with a flush. A flush always comes with a PC hold. No select ever takes the unused code. A source register of 0 is never forwarded. A flush run never exceeds the shadow length. Quiet outputs under reset are checked as well. The exact select chosen for each register match, the precise set of load-use conditions, the start cycle of the shadow and its deferral behind a stall can only be shown by the bench's sweeps and scripted sequences, which compare against values it works out on its own.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;
endpackage

// File: rtl/hzc_fwd_pick.sv
module hzc_fwd_pick
    import hzc_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output opnd_src_e         sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_wen && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);
        if (mem_hit)
            sel = SRC_MEM;
        else if (wb_hit)
            sel = SRC_WB;
        else
            sel = SRC_REGFILE;
    end
endmodule

// File: rtl/hzc_load_use.sv
module hzc_load_use #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] dec_rs1,
    input  logic [REG_AW-1:0] dec_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_load,
    output logic              hit
);
    always_comb begin
        hit = ex_load && ex_wen && (ex_rd != '0)
              && ((ex_rd == dec_rs1) || (ex_rd == dec_rs2));
    end
endmodule

// File: rtl/hzc_shadow.sv
module hzc_shadow #(
    parameter int BR_SHADOW = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BR_SHADOW + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } shadow_st_t;

    shadow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.left != '0)
            st_d.left = st_q.left - 1'b1;
        else if (start)
            st_d.left = CW'(BR_SHADOW - 1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy = (st_q.left != '0);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_AW    = 5,
    parameter int BR_SHADOW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] dec_rs1,
    input  logic [REG_AW-1:0] dec_rs2,
    input  logic              dec_branch,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output logic              pc_hold,
    output logic              fd_hold,
    output logic              fd_flush,
    output logic              de_bubble,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b
);
    localparam int NOPND = 2;

    logic [REG_AW-1:0] opnd_src [NOPND];
    opnd_src_e         opnd_sel [NOPND];
    logic              lu_raw;
    logic              sh_busy;
    logic              sh_start;
    logic              lu_live;

    assign opnd_src[0] = ex_rs1;
    assign opnd_src[1] = ex_rs2;

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        hzc_fwd_pick #(.REG_AW(REG_AW)) u_pick (
            .src     (opnd_src[g]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (opnd_sel[g])
        );
    end

    hzc_load_use #(.REG_AW(REG_AW)) u_lu (
        .dec_rs1 (dec_rs1),
        .dec_rs2 (dec_rs2),
        .ex_rd   (ex_rd),
        .ex_wen  (ex_wen),
        .ex_load (ex_load),
        .hit     (lu_raw)
    );

    always_comb begin
        lu_live  = lu_raw && !sh_busy;
        sh_start = dec_branch && !lu_raw && !sh_busy;
    end

    hzc_shadow #(.BR_SHADOW(BR_SHADOW)) u_shadow (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .busy  (sh_busy)
    );

    always_comb begin
        if (rst) begin
            pc_hold   = 1'b0;
            fd_hold   = 1'b0;
            fd_flush  = 1'b0;
            de_bubble = 1'b0;
            fwd_a     = SRC_REGFILE;
            fwd_b     = SRC_REGFILE;
        end else begin
            fd_flush  = sh_start || sh_busy;
            fd_hold   = lu_live;
            de_bubble = lu_live;
            pc_hold   = lu_live || fd_flush;
            fwd_a     = opnd_sel[0];
            fwd_b     = opnd_sel[1];
        end
    end
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
    parameter int REG_AW    = 5,
    parameter int BR_SHADOW = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] ex_rs1,
    input logic [REG_AW-1:0] ex_rs2,
    input logic              pc_hold,
    input logic              fd_hold,
    input logic              fd_flush,
    input logic              de_bubble,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b
);
    localparam int RW = $clog2(BR_SHADOW + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !fd_flush)
            run_q <= '0;
        else if (run_q < RW'(BR_SHADOW + 1))
            run_q <= run_q + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (!pc_hold && !fd_hold && !fd_flush && !de_bubble
                 && fwd_a == 2'b00 && fwd_b == 2'b00)); // R1

    AST_BUBBLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        de_bubble |-> (pc_hold && fd_hold && !fd_flush)); // R5

    AST_FLUSH_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
        fd_flush |-> (pc_hold && !fd_hold && !de_bubble)); // R7

    AST_FLUSH_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        fd_flush |-> (run_q < RW'(BR_SHADOW))); // R10

    AST_SEL_CODE_A: assert property (@(posedge clk) disable iff (rst)
        fwd_a != 2'b11); // R2

    AST_SEL_CODE_B: assert property (@(posedge clk) disable iff (rst)
        fwd_b != 2'b11); // R3

    AST_ZERO_SRC_A: assert property (@(posedge clk) disable iff (rst)
        (ex_rs1 == '0) |-> (fwd_a == 2'b00)); // R4

    AST_ZERO_SRC_B: assert property (@(posedge clk) disable iff (rst)
        (ex_rs2 == '0) |-> (fwd_b == 2'b00)); // R9
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(
    .REG_AW    (REG_AW),
    .BR_SHADOW (BR_SHADOW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ex_rs1    (ex_rs1),
    .ex_rs2    (ex_rs2),
    .pc_hold   (pc_hold),
    .fd_hold   (fd_hold),
    .fd_flush  (fd_flush),
    .de_bubble (de_bubble),
    .fwd_a     (fwd_a),
    .fwd_b     (fwd_b)
);

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic          dec_branch, ex_wen, ex_load, mem_wen, wb_wen;
    logic          pc_hold, fd_hold, fd_flush, de_bubble;
    logic [1:0]    fwd_a, fwd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pipe_hazard_ctrl #(.REG_AW(AW), .BR_SHADOW(3)) uut (
        .clk(clk), .rst(rst),
        .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_branch(dec_branch),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
        .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
        .pc_hold(pc_hold), .fd_hold(fd_hold), .fd_flush(fd_flush),
        .de_bubble(de_bubble), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    function automatic logic [1:0] exp_sel(input int src, input int mrd, input int mw,
                                           input int wrd, input int ww);
        if (mw != 0 && mrd != 0 && mrd == src) return 2'b10;
        if (ww != 0 && wrd != 0 && wrd == src) return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        dec_rs1 = '0; dec_rs2 = '0; dec_branch = 1'b0;
        ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_wen = 1'b0; ex_load = 1'b0;
        mem_rd = '0; mem_wen = 1'b0; wb_rd = '0; wb_wen = 1'b0;
    endtask

    function automatic logic [7:0] hz();
        return {4'b0, pc_hold, fd_hold, fd_flush, de_bubble};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        // R1: outputs quiet under reset even with every hazard condition present
        @(negedge clk);
        dec_branch = 1'b1; ex_load = 1'b1; ex_wen = 1'b1; ex_rd = 5'd3; dec_rs1 = 5'd3;
        mem_wen = 1'b1; mem_rd = 5'd4; ex_rs1 = 5'd4; ex_rs2 = 5'd4;
        #1 chk("R1 reset hazards", hz(), 8'h0);
        chk("R1 reset selects", {4'b0, fwd_a, fwd_b}, 8'h0);
        @(negedge clk); idle(); rst = 1'b0;
        #1 chk("R1 idle after reset", hz(), 8'h0);

        // R2 R3 R4 R9: sweep operand A over small register range, operand B fixed
        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 4; m++)
                for (int mw = 0; mw < 2; mw++)
                    for (int w = 0; w < 4; w++)
                        for (int ww = 0; ww < 2; ww++) begin
                            @(negedge clk);
                            ex_rs1 = AW'(s); ex_rs2 = AW'(7);
                            mem_rd = AW'(m); mem_wen = mw[0];
                            wb_rd = AW'(w); wb_wen = ww[0];
                            #1;
                            chk("R2/R3/R4 fwd_a sweep", {6'b0, fwd_a},
                                {6'b0, exp_sel(s, m, mw, w, ww)});
                            chk("R9 fwd_b independent", {6'b0, fwd_b}, 8'h0);
                        end
        // R9: both operands differ in source
        @(negedge clk);
        ex_rs1 = 5'd2; ex_rs2 = 5'd5; mem_rd = 5'd2; mem_wen = 1'b1; wb_rd = 5'd5; wb_wen = 1'b1;
        #1 chk("R9 fwd_a mem", {6'b0, fwd_a}, 8'h2);
        chk("R9 fwd_b wb", {6'b0, fwd_b}, 8'h1);
        @(negedge clk); ex_rs1 = 5'd5; ex_rs2 = 5'd2;
        #1 chk("R9 fwd_a wb", {6'b0, fwd_a}, 8'h1);
        chk("R9 fwd_b mem", {6'b0, fwd_b}, 8'h2);
        @(negedge clk); wb_rd = 5'd2;
        #1 chk("R2 priority both match", {6'b0, fwd_b}, 8'h2);

        // R5 R6: load-use sweep
        for (int rd = 0; rd < 4; rd++)
            for (int ld = 0; ld < 2; ld++)
                for (int we = 0; we < 2; we++)
                    for (int a = 0; a < 4; a++)
                        for (int b = 0; b < 4; b++) begin
                            @(negedge clk);
                            idle();
                            ex_rd = AW'(rd); ex_load = ld[0]; ex_wen = we[0];
                            dec_rs1 = AW'(a); dec_rs2 = AW'(b);
                            #1;
                            if (ld != 0 && we != 0 && rd != 0 && (rd == a || rd == b))
                                chk("R5 load-use stall", hz(), 8'b1101);
                            else
                                chk("R6 no stall", hz(), 8'h0);
                        end

        // R7: branch shadow of exactly three cycles
        @(negedge clk); idle(); dec_branch = 1'b1;
        #1 chk("R7 shadow cycle 1", hz(), 8'b1010);
        @(negedge clk); dec_branch = 1'b0;
        #1 chk("R7 shadow cycle 2", hz(), 8'b1010);
        @(negedge clk);
        #1 chk("R7 shadow cycle 3", hz(), 8'b1010);
        @(negedge clk);
        #1 chk("R7 shadow ended", hz(), 8'h0);

        // R10: branch flag and load-use match held during shadow are ignored
        @(negedge clk); dec_branch = 1'b1;
        #1 chk("R10 start", hz(), 8'b1010);
        @(negedge clk); ex_load = 1'b1; ex_wen = 1'b1; ex_rd = 5'd6; dec_rs2 = 5'd6;
        #1 chk("R10 shadow 2 ignores", hz(), 8'b1010);
        @(negedge clk);
        #1 chk("R10 shadow 3 ignores", hz(), 8'b1010);
        @(negedge clk); idle();
        #1 chk("R10 not extended", hz(), 8'h0);

        // R8: load-use with branch in decode defers the shadow by one cycle
        @(negedge clk); dec_branch = 1'b1; ex_load = 1'b1; ex_wen = 1'b1; ex_rd = 5'd9; dec_rs1 = 5'd9;
        #1 chk("R8 stall first", hz(), 8'b1101);
        @(negedge clk); ex_load = 1'b0; ex_wen = 1'b0; ex_rd = '0;
        #1 chk("R8 shadow 1", hz(), 8'b1010);
        @(negedge clk); dec_branch = 1'b0;
        #1 chk("R8 shadow 2", hz(), 8'b1010);
        @(negedge clk);
        #1 chk("R8 shadow 3", hz(), 8'b1010);
        @(negedge clk);
        #1 chk("R8 shadow ended", hz(), 8'h0);

        // R1: reset in the middle of a shadow cancels it
        @(negedge clk); dec_branch = 1'b1;
        #1 chk("R1 shadow start", hz(), 8'b1010);
        @(negedge clk); dec_branch = 1'b0; rst = 1'b1;
        #1 chk("R1 quiet in shadow", hz(), 8'h0);
        @(negedge clk); rst = 1'b0;
        #1 chk("R1 shadow cleared", hz(), 8'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule